// File: doc/BRIEF.md
# Interleaved Frame-Buffer Raster Funnel

The funnel reads a frame buffer whose pixels are spread over a rectangular array of node memories and turns them into one raster-ordered pixel stream for a video controller. Screen pixels are dealt out to the nodes in tiles of n columns by m rows. Each node keeps the pixels it owns in its own local memory, packed line by line. The funnel walks the screen left to right and top to bottom. For every pixel it works out the owning node and that node's local address, reads the word through the node's read port, and delivers it in order on a valid/ready stream. The stream carries a line-start flag and a frame-start flag.

Software sets the tile shape, the display width and height, and which of the two display banks in each node is shown. These settings are held in a shadow copy and are taken into use only as the first pixel of a frame is read. A frame in progress therefore never changes shape or bank part-way through. Node reads have a fixed two-cycle latency. The funnel keeps enough reads in flight to deliver one pixel per cycle, and it throttles issue when the consumer stalls, so nothing is lost.

Top module: `fb_raster_funnel`

## Requirements
- R1: With tile code 0 (4 columns by 4 rows), pixel (x,y) comes from node 4*(x mod 4)+(y mod 4) at local address (y div 4)*(W/4)+(x div 4), and pixels leave in raster order with x running fastest.
- R2: cfg_geom selects the tile of n columns by m rows: 0 gives 4x4 (16 nodes), 1 gives 5x4 (20), 2 gives 8x4 (32), 3 gives 8x5 (40) and 4 gives 8x8 (64). The owner is (x mod n)*m+(y mod m) and the local address is (y div m)*(W div n)+(x div n), for a width W that is a multiple of n.
- R3: Tile codes 5, 6 and 7 behave exactly like code 0.
- R4: pix_sol is high exactly on pixels with x=0. pix_sof is high exactly on pixel (0,0), and pix_sof never appears without pix_sol.
- R5: At most one node is read per cycle. A node samples node_rd_en and node_rd_addr at a clock edge and shows the word on its slice of node_rd_data after the following edge. From the sixth cycle after reset release, pix_valid stays high on every cycle.
- R6: While pix_ready is low, pix_valid, pix_data and both flags hold their values. No pixel is dropped or repeated.
- R7: node_rd_bank goes with every read. A cfg_bank value takes effect from the first pixel of the next frame and is constant for all reads of that frame. It is visible in the delivered words.
- R8: A configuration write during a frame leaves that frame's pixels unchanged. The last write made before the next frame's first read decides that frame.
- R9: While rst_n is low, pix_valid and every node_rd_en are low. The first frame after reset uses DEF_GEOM, DEF_WIDTH, DEF_HEIGHT and bank 0.
- R10: After pixel (W-1,H-1), the next pixel delivered is (0,0) of a new frame, with no gap in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the shadow configuration |
| cfg_geom | input | 3 | Tile shape code |
| cfg_width | input | X_W | Display width in pixels |
| cfg_height | input | Y_W | Display height in lines |
| cfg_bank | input | 1 | Display bank to show |
| node_rd_en | output | NODES | One-hot read request, one bit per node |
| node_rd_addr | output | ADDR_W | Local word address, shared by all nodes |
| node_rd_bank | output | 1 | Bank half for the current read |
| node_rd_data | input | NODES*WORD_W | Read words, node i in slice i |
| pix_valid | output | 1 | Output pixel available |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_data | output | WORD_W | Pixel word |
| pix_sol | output | 1 | First pixel of a line |
| pix_sof | output | 1 | First pixel of a frame |

## Verification
On every cycle, the assertions check the local invariants: the tile counters stay inside the selected tile, the bank holds steady within a frame, reads in flight plus queued words never exceed the queue depth, the queue never overflows or underflows, a stalled output holds, and frame start implies line start. Only the bench's scenarios can show that the node and address mapping is correct for each tile shape and for the out-of-range codes. The same applies to configuration written mid-frame landing exactly on the next frame, to bank switching seen in the data, and to continuous output across frame wraps under random and heavy back-pressure.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

   localparam int GEOM_W = 3;
   localparam int DIM_W  = 4;
   localparam int FULL_TILE_NODES = 64;

   localparam logic [GEOM_W-1:0] GEOM_T4X4 = 3'd0;
   localparam logic [GEOM_W-1:0] GEOM_T5X4 = 3'd1;
   localparam logic [GEOM_W-1:0] GEOM_T8X4 = 3'd2;
   localparam logic [GEOM_W-1:0] GEOM_T8X5 = 3'd3;
   localparam logic [GEOM_W-1:0] GEOM_T8X8 = 3'd4;

   // tile columns (x direction) for a shape code; unknown codes fall back to 4x4
   function automatic logic [DIM_W-1:0] tile_cols(input logic [GEOM_W-1:0] g);
      logic [DIM_W-1:0] r;
      case (g)
         GEOM_T5X4:                       r = 4'd5;
         GEOM_T8X4, GEOM_T8X5, GEOM_T8X8: r = 4'd8;
         default:                         r = 4'd4;
      endcase
      return r;
   endfunction

   // tile rows (y direction) for a shape code
   function automatic logic [DIM_W-1:0] tile_rows(input logic [GEOM_W-1:0] g);
      logic [DIM_W-1:0] r;
      case (g)
         GEOM_T8X5: r = 4'd5;
         GEOM_T8X8: r = 4'd8;
         default:   r = 4'd4;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/fbf_raster_walk.sv
module fbf_raster_walk
   import fbf_pkg::*;
#(
   parameter int X_W        = 10,
   parameter int Y_W        = 10,
   parameter int ADDR_W     = 12,
   parameter int NODE_W     = 6,
   parameter int DEF_GEOM   = 0,
   parameter int DEF_WIDTH  = 16,
   parameter int DEF_HEIGHT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [GEOM_W-1:0] cfg_geom,
   input  logic [X_W-1:0]    cfg_width,
   input  logic [Y_W-1:0]    cfg_height,
   input  logic              cfg_bank,
   input  logic              step,
   output logic [NODE_W-1:0] node_idx,
   output logic [ADDR_W-1:0] addr,
   output logic              bank,
   output logic              sol,
   output logic              sof
);

   localparam int PROD_W = 2 * DIM_W;

   if (NODE_W < 6) begin : g_bad_node_w
      $error("fbf_raster_walk: NODE_W too small for an 8x8 tile");
   end
   if (DEF_WIDTH >= (1 << X_W) || DEF_HEIGHT >= (1 << Y_W)) begin : g_bad_def
      $error("fbf_raster_walk: default resolution does not fit X_W/Y_W");
   end

   // shadow copy written by software, active copy used inside a frame
   logic [GEOM_W-1:0] sh_geom, ac_geom, eff_geom;
   logic [X_W-1:0]    sh_w, ac_w, eff_w;
   logic [Y_W-1:0]    sh_h, ac_h, eff_h;
   logic              sh_bank, ac_bank, eff_bank;

   // raster position and its tile quotient / remainder
   logic [X_W-1:0]    x;
   logic [Y_W-1:0]    y;
   logic [DIM_W-1:0]  xn, ym;
   logic [ADDR_W-1:0] xq, base;

   logic              at_origin, last_col, last_row;
   logic [DIM_W-1:0]  n_cols, m_rows;
   logic [PROD_W-1:0] node_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_geom <= GEOM_W'(DEF_GEOM);
         sh_w    <= X_W'(DEF_WIDTH);
         sh_h    <= Y_W'(DEF_HEIGHT);
         sh_bank <= 1'b0;
      end else if (cfg_we) begin
         sh_geom <= cfg_geom;
         sh_w    <= cfg_width;
         sh_h    <= cfg_height;
         sh_bank <= cfg_bank;
      end
   end

   assign at_origin = (x == '0) && (y == '0);

   // the first read of a frame already uses the shadow values
   always_comb begin
      if (at_origin) begin
         eff_geom = sh_geom;
         eff_w    = sh_w;
         eff_h    = sh_h;
         eff_bank = sh_bank;
      end else begin
         eff_geom = ac_geom;
         eff_w    = ac_w;
         eff_h    = ac_h;
         eff_bank = ac_bank;
      end
   end

   assign n_cols   = tile_cols(eff_geom);
   assign m_rows   = tile_rows(eff_geom);
   assign last_col = (x == eff_w - X_W'(1));
   assign last_row = (y == eff_h - Y_W'(1));

   assign node_full = ({{DIM_W{1'b0}}, xn} * {{DIM_W{1'b0}}, m_rows}) + {{DIM_W{1'b0}}, ym};
   assign node_idx  = node_full[NODE_W-1:0];
   assign addr      = base + xq;
   assign bank      = eff_bank;
   assign sol       = (x == '0);
   assign sof       = at_origin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac_geom <= GEOM_W'(DEF_GEOM);
         ac_w    <= X_W'(DEF_WIDTH);
         ac_h    <= Y_W'(DEF_HEIGHT);
         ac_bank <= 1'b0;
         x       <= '0;
         y       <= '0;
         xn      <= '0;
         ym      <= '0;
         xq      <= '0;
         base    <= '0;
      end else if (step) begin
         if (at_origin) begin
            ac_geom <= sh_geom;
            ac_w    <= sh_w;
            ac_h    <= sh_h;
            ac_bank <= sh_bank;
         end
         if (last_col) begin
            x  <= '0;
            xn <= '0;
            xq <= '0;
            if (last_row) begin
               y    <= '0;
               ym   <= '0;
               base <= '0;
            end else begin
               y <= y + Y_W'(1);
               if (ym == m_rows - DIM_W'(1)) begin
                  ym   <= '0;
                  base <= base + xq + ADDR_W'(1);
               end else begin
                  ym <= ym + DIM_W'(1);
               end
            end
         end else begin
            x <= x + X_W'(1);
            if (xn == n_cols - DIM_W'(1)) begin
               xn <= '0;
               xq <= xq + ADDR_W'(1);
            end else begin
               xn <= xn + DIM_W'(1);
            end
         end
      end
   end

   // bank seen on the previous read, used only by the check below
   logic prev_bank, prev_bank_v;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_bank   <= 1'b0;
         prev_bank_v <= 1'b0;
      end else if (step) begin
         prev_bank   <= bank;
         prev_bank_v <= 1'b1;
      end
   end

   AST_TILE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (xn < n_cols) && (ym < m_rows)); // R2

   AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !at_origin && prev_bank_v) |-> (bank == prev_bank)); // R7

endmodule

// File: rtl/fbf_read_pipe.sv
module fbf_read_pipe #(
   parameter int NODES  = 64,
   parameter int WORD_W = 32,
   parameter int NODE_W = 6,
   parameter int LAT    = 2,
   parameter int CNT_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    issue,
   input  logic [NODE_W-1:0]       node_idx,
   input  logic                    sol,
   input  logic                    sof,
   input  logic [NODES*WORD_W-1:0] node_rd_data,
   output logic [NODES-1:0]        node_rd_en,
   output logic                    ret_valid,
   output logic [WORD_W-1:0]       ret_data,
   output logic                    ret_sol,
   output logic                    ret_sof,
   output logic [CNT_W-1:0]        inflight
);

   if (LAT < 1) begin : g_bad_lat
      $error("fbf_read_pipe: LAT must be at least 1");
   end
   if ((1 << NODE_W) < NODES) begin : g_bad_nodes
      $error("fbf_read_pipe: NODE_W cannot index every node");
   end

   // one-hot request decode, one bit per node
   for (genvar i = 0; i < NODES; i++) begin : g_en
      assign node_rd_en[i] = issue && (node_idx == NODE_W'(i));
   end

   logic [LAT-1:0] tag_v;

   // tag pipeline that follows each read until its word returns
   for (genvar s = 0; s < LAT; s++) begin : g_stage
      logic              v, so, sf;
      logic [NODE_W-1:0] nd;
      logic              v_in, so_in, sf_in;
      logic [NODE_W-1:0] nd_in;
      if (s == 0) begin : g_head
         assign v_in  = issue;
         assign so_in = sol;
         assign sf_in = sof;
         assign nd_in = node_idx;
      end else begin : g_body
         assign v_in  = g_stage[s-1].v;
         assign so_in = g_stage[s-1].so;
         assign sf_in = g_stage[s-1].sf;
         assign nd_in = g_stage[s-1].nd;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v  <= 1'b0;
            so <= 1'b0;
            sf <= 1'b0;
            nd <= '0;
         end else begin
            v  <= v_in;
            so <= so_in;
            sf <= sf_in;
            nd <= nd_in;
         end
      end
      assign tag_v[s] = v;
   end

   assign ret_valid = g_stage[LAT-1].v;
   assign ret_sol   = g_stage[LAT-1].so;
   assign ret_sof   = g_stage[LAT-1].sf;
   assign ret_data  = node_rd_data[int'(g_stage[LAT-1].nd) * WORD_W +: WORD_W];

   always_comb begin
      inflight = '0;
      for (int k = 0; k < LAT; k++) begin
         inflight = inflight + CNT_W'(tag_v[k]);
      end
   end

endmodule

// File: rtl/fbf_skid_fifo.sv
module fbf_skid_fifo #(
   parameter int W     = 34,
   parameter int DEPTH = 4,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic             empty,
   output logic [CNT_W-1:0] count
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("fbf_skid_fifo: DEPTH must be at least 2");
   end
   if ((1 << CNT_W) <= DEPTH) begin : g_bad_cnt
      $error("fbf_skid_fifo: CNT_W too narrow for DEPTH");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wp] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) begin
            wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
         end
         if (pop) begin
            rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + PTR_W'(1);
         end
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign dout  = mem[rp];
   assign empty = (count == '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(DEPTH)) || pop); // R6

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0)); // R6

endmodule

// File: rtl/fb_raster_funnel.sv
module fb_raster_funnel
   import fbf_pkg::*;
#(
   parameter int NODES      = 64,
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 12,
   parameter int X_W        = 10,
   parameter int Y_W        = 10,
   parameter int LAT        = 2,
   parameter int DEF_GEOM   = 0,
   parameter int DEF_WIDTH  = 16,
   parameter int DEF_HEIGHT = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [2:0]              cfg_geom,
   input  logic [X_W-1:0]          cfg_width,
   input  logic [Y_W-1:0]          cfg_height,
   input  logic                    cfg_bank,
   output logic [NODES-1:0]        node_rd_en,
   output logic [ADDR_W-1:0]       node_rd_addr,
   output logic                    node_rd_bank,
   input  logic [NODES*WORD_W-1:0] node_rd_data,
   output logic                    pix_valid,
   input  logic                    pix_ready,
   output logic [WORD_W-1:0]       pix_data,
   output logic                    pix_sol,
   output logic                    pix_sof
);

   localparam int NODE_W = $clog2(NODES);
   localparam int DEPTH  = LAT + 2;
   localparam int CNT_W  = $clog2(2 * DEPTH + 1);
   localparam int ENT_W  = WORD_W + 2;

   if (NODES < FULL_TILE_NODES) begin : g_bad_nodes
      $error("fb_raster_funnel: NODES must cover the largest tile");
   end
   if (WORD_W < 1 || ADDR_W < 1) begin : g_bad_widths
      $error("fb_raster_funnel: WORD_W and ADDR_W must be positive");
   end

   logic              run;
   logic              issue;
   logic [NODE_W-1:0] w_node;
   logic [ADDR_W-1:0] w_addr;
   logic              w_bank, w_sol, w_sof;
   logic              r_valid, r_sol, r_sof;
   logic [WORD_W-1:0] r_data;
   logic [CNT_W-1:0]  inflight, fifo_cnt, pending;
   logic [ENT_W-1:0]  fifo_out;
   logic              fifo_empty, pop;

   always_ff @(posedge clk) begin
      if (!rst_n) run <= 1'b0;
      else        run <= 1'b1;
   end

   // credit rule: never more reads outstanding than the queue can hold
   assign pending = inflight + fifo_cnt;
   assign issue   = run && (pending < CNT_W'(DEPTH));

   fbf_raster_walk #(
      .X_W        (X_W),
      .Y_W        (Y_W),
      .ADDR_W     (ADDR_W),
      .NODE_W     (NODE_W),
      .DEF_GEOM   (DEF_GEOM),
      .DEF_WIDTH  (DEF_WIDTH),
      .DEF_HEIGHT (DEF_HEIGHT)
   ) i_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_geom   (cfg_geom),
      .cfg_width  (cfg_width),
      .cfg_height (cfg_height),
      .cfg_bank   (cfg_bank),
      .step       (issue),
      .node_idx   (w_node),
      .addr       (w_addr),
      .bank       (w_bank),
      .sol        (w_sol),
      .sof        (w_sof)
   );

   assign node_rd_addr = w_addr;
   assign node_rd_bank = w_bank;

   fbf_read_pipe #(
      .NODES  (NODES),
      .WORD_W (WORD_W),
      .NODE_W (NODE_W),
      .LAT    (LAT),
      .CNT_W  (CNT_W)
   ) i_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue        (issue),
      .node_idx     (w_node),
      .sol          (w_sol),
      .sof          (w_sof),
      .node_rd_data (node_rd_data),
      .node_rd_en   (node_rd_en),
      .ret_valid    (r_valid),
      .ret_data     (r_data),
      .ret_sol      (r_sol),
      .ret_sof      (r_sof),
      .inflight     (inflight)
   );

   assign pop = pix_valid && pix_ready;

   fbf_skid_fifo #(
      .W     (ENT_W),
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
   ) i_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (r_valid),
      .din   ({r_sol, r_sof, r_data}),
      .pop   (pop),
      .dout  (fifo_out),
      .empty (fifo_empty),
      .count (fifo_cnt)
   );

   assign pix_valid = !fifo_empty;
   assign pix_sol   = fifo_out[ENT_W-1];
   assign pix_sof   = fifo_out[ENT_W-2];
   assign pix_data  = fifo_out[WORD_W-1:0];

   AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pending <= CNT_W'(DEPTH)); // R5

   AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(node_rd_en) <= 1); // R5

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready) |=> pix_valid && $stable(pix_data)
                                    && $stable(pix_sol) && $stable(pix_sof)); // R6

   AST_SOF_HAS_SOL: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_sof) |-> pix_sol); // R4

endmodule

// File: tb/test_fb_raster_funnel.sv
`timescale 1ns/1ps
module test_fb_raster_funnel;

   localparam int NODES  = 64;
   localparam int WORD_W = 32;
   localparam int ADDR_W = 12;
   localparam int X_W    = 10;
   localparam int Y_W    = 10;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    cfg_we = 1'b0;
   logic [2:0]              cfg_geom = '0;
   logic [X_W-1:0]          cfg_width = '0;
   logic [Y_W-1:0]          cfg_height = '0;
   logic                    cfg_bank = 1'b0;
   logic [NODES-1:0]        node_rd_en;
   logic [ADDR_W-1:0]       node_rd_addr;
   logic                    node_rd_bank;
   logic [NODES*WORD_W-1:0] node_rd_data;
   logic                    pix_valid;
   logic                    pix_ready = 1'b1;
   logic [WORD_W-1:0]       pix_data;
   logic                    pix_sol, pix_sof;

   always #4 clk = ~clk; // 125 MHz

   fb_raster_funnel i_fb_raster_funnel (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_geom(cfg_geom),
      .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_bank(cfg_bank),
      .node_rd_en(node_rd_en), .node_rd_addr(node_rd_addr), .node_rd_bank(node_rd_bank),
      .node_rd_data(node_rd_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .pix_data(pix_data), .pix_sol(pix_sol), .pix_sof(pix_sof)
   );

   // node memory model: word encodes bank, node and address
   function automatic logic [31:0] mk_word(input int node, input int a, input logic b);
      return {b, 7'(node), 24'(a)};
   endfunction

   logic [31:0] s1 [NODES];
   logic [31:0] s2 [NODES];
   initial begin
      for (int i = 0; i < NODES; i++) begin s1[i] = '0; s2[i] = '0; end
   end
   always @(posedge clk) begin
      for (int i = 0; i < NODES; i++) begin
         if (node_rd_en[i]) s1[i] <= mk_word(i, int'(node_rd_addr), node_rd_bank);
         s2[i] <= s1[i];
      end
   end
   always_comb begin
      for (int i = 0; i < NODES; i++) node_rd_data[i*WORD_W +: WORD_W] = s2[i];
   end

   // bench view of the configuration
   int    b_geom = 0, b_w = 16, b_h = 8;
   logic  b_bank = 1'b0;
   int    n_cmp = 0, n_bad = 0;
   int    ready_mode = 0;
   int    sof_seen = 0;
   bit    done = 1'b0;

   logic [33:0] exp_q [$];
   string cur_tag = "R1";
   int    cur_len = 0, prev_len = 0, frame_pix = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
   endtask

   // build one frame of expected pixels: {sol, sof, word}
   task automatic gen_frame();
      int n, m;
      case (b_geom)
         1: begin n = 5; m = 4; cur_tag = "R2"; end
         2: begin n = 8; m = 4; cur_tag = "R2"; end
         3: begin n = 8; m = 5; cur_tag = "R2"; end
         4: begin n = 8; m = 8; cur_tag = "R2"; end
         0: begin n = 4; m = 4; cur_tag = "R1"; end
         default: begin n = 4; m = 4; cur_tag = "R3"; end
      endcase
      prev_len = cur_len;
      cur_len  = b_w * b_h;
      for (int y = 0; y < b_h; y++) begin
         for (int x = 0; x < b_w; x++) begin
            int nd, ad;
            nd = (x % n) * m + (y % m);
            ad = (y / m) * (b_w / n) + (x / n);
            exp_q.push_back({(x == 0), (x == 0 && y == 0), mk_word(nd, ad, b_bank)});
         end
      end
   endtask

   // per-clock comparison at the falling edge
   int   since_rst = 0;
   logic prev_stall = 1'b0;
   logic [33:0] prev_out = '0;
   always @(negedge clk) begin
      if (!rst_n) begin
         // R9: nothing valid and no reads while in reset
         chk(!pix_valid && (node_rd_en == '0), "R9", "reset outputs",
             {31'b0, pix_valid, 32'(node_rd_en != '0)}, 64'd0);
         since_rst  = 0;
         prev_stall = 1'b0;
      end else if (!done) begin
         since_rst++;
         if (since_rst > 6) begin
            chk(pix_valid, "R5", "continuous valid", 64'(pix_valid), 64'd1);
         end
         if (prev_stall) begin
            chk(pix_valid && ({pix_sol, pix_sof, pix_data} == prev_out), "R6",
                "held under stall", 64'({pix_sol, pix_sof, pix_data}), 64'(prev_out));
         end
         if (pix_valid && pix_ready) begin
            logic [33:0] e;
            if (exp_q.size() == 0) gen_frame();
            e = exp_q.pop_front();
            chk(pix_data == e[31:0], cur_tag, "pixel word", 64'(pix_data), 64'(e[31:0]));
            chk(pix_data[31] == e[31], "R7", "bank bit", 64'(pix_data[31]), 64'(e[31]));
            chk({pix_sol, pix_sof} == e[33:32], "R4 R10", "line/frame flags",
                64'({pix_sol, pix_sof}), 64'(e[33:32]));
            if (pix_sof) begin
               if (sof_seen > 0) begin
                  chk(frame_pix == prev_len, "R8", "previous frame length",
                      64'(frame_pix), 64'(prev_len));
               end
               sof_seen++;
               frame_pix = 0;
            end
            frame_pix++;
         end
         prev_stall = pix_valid && !pix_ready;
         prev_out   = {pix_sol, pix_sof, pix_data};
      end
   end

   // back-pressure patterns
   int rcnt = 0;
   always @(posedge clk) begin
      #1;
      rcnt++;
      case (ready_mode)
         0:       pix_ready = 1'b1;
         1:       pix_ready = 1'($urandom % 2);
         default: pix_ready = (rcnt % 4 == 0);
      endcase
   end

   task automatic cfg_write(input int g, input int w, input int h, input logic b);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_geom = 3'(g); cfg_width = X_W'(w); cfg_height = Y_W'(h); cfg_bank = b;
      b_geom = g; b_w = w; b_h = h; b_bank = b;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      // R9: frame 0 uses reset defaults 4x4, 16x8, bank 0 (R1)
      wait (sof_seen >= 1); repeat (3) @(posedge clk);
      cfg_write(1, 20, 6, 1'b1);          // R2 5x4, R7 bank 1
      ready_mode = 1;
      wait (sof_seen >= 2); repeat (3) @(posedge clk);
      cfg_write(2, 24, 4, 1'b0);          // R2 8x4
      ready_mode = 2;
      wait (sof_seen >= 3); repeat (3) @(posedge clk);
      cfg_write(3, 16, 10, 1'b1);         // R2 8x5
      ready_mode = 1;
      wait (sof_seen >= 4); repeat (3) @(posedge clk);
      cfg_write(4, 32, 9, 1'b0);          // R2 8x8
      ready_mode = 0;
      wait (sof_seen >= 5); repeat (3) @(posedge clk);
      cfg_write(2, 8, 4, 1'b0);           // R8 overwritten before the frame starts
      repeat (20) @(posedge clk);
      cfg_write(6, 8, 4, 1'b1);           // R3 unknown code acts as 4x4
      ready_mode = 2;
      wait (sof_seen >= 7); repeat (3) @(posedge clk);
      ready_mode = 1;
      repeat (60) @(posedge clk);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d frames", sof_seen, 7);
         summary();
         $finish;
      end
   end

endmodule